// File: doc/BRIEF.md
# Uplink Short Scrambling Code Generator

This block produces a 256-chip complex scrambling sequence from a 24-bit code index. Three 8-stage recursive generators run side by side: one over the integers modulo 4 and two over bits. The index is split into three bytes. The low byte seeds the quaternary generator after a transformation, and the middle and high bytes seed the two binary generators directly. For each chip the three outputs are added modulo 4 into a symbol z. The symbol is then mapped to an in-phase and a quadrature sign, each encoded in two's complement. The base sequence is 255 chips long. A 256th chip, equal to chip 0, closes each period. The generators are then reseeded from the index held inside the block, and the next period begins.

A one-cycle `start` strobe captures the index and begins a period. While `chip_valid` is high, the current chip is presented continuously. It is consumed by a one-cycle `chip_en` pulse, which advances to the next chip on the following edge. The controller has three states. IDLE runs from reset until the first `start`. BASE presents chips 0 to 254 from the generators. TAIL presents chip 255 from a register holding chip 0. The transitions are: any state to BASE on `start`; BASE to BASE on `chip_en` for chips 0 to 253; BASE to TAIL on `chip_en` at chip 254; TAIL to BASE on `chip_en`, which reseeds the generators.

Top module: `ulsc_short_code_gen`

## Requirements
- R1: From reset until the first `start`, `chip_valid`, `period_start`, `chip_i` and `chip_q` are 0, and `chip_en` has no effect.
- R2: The cycle after a `start` strobe, `chip_valid` is 1 and `period_start` is 1, with chip 0 of the sequence for the index presented at the time of `start`.
- R3: The quaternary sequence is seeded with a(0) = 2·r0+1 mod 4 and a(i) = 2·r_i mod 4 for i = 1..7, where r is index bits 7:0. It follows a(n) = 3a(n-3) + a(n-5) + 3a(n-6) + 2a(n-7) + 3a(n-8) mod 4.
- R4: b(i) = index bit 8+i and c(i) = index bit 16+i for i = 0..7. The sequences follow b(n) = b(n-1)+b(n-3)+b(n-7)+b(n-8) mod 2 and c(n) = c(n-3)+c(n-4)+c(n-5)+c(n-8) mod 2.
- R5: For chips 0 to 254, z(n) = a(n)+2b(n)+2c(n) mod 4. The outputs (I,Q) are (+1,+1) for z=0, (-1,+1) for z=1, (-1,-1) for z=2 and (+1,-1) for z=3, with +1 encoded as 2'b01 and -1 as 2'b11.
- R6: Chip 255 equals chip 0 of the same period.
- R7: Consuming chip 255 brings chip 0 back with `period_start` high, so the code repeats every 256 chips.
- R8: While `chip_en` and `start` are low, all outputs hold their values.
- R9: A `start` during a period restarts at chip 0 of the new index the next cycle. A `chip_en` in the same cycle is ignored.
- R10: `code_index` is sampled only when `start` is high. Changes at any other time, including across a period wrap, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture index and begin at chip 0 |
| chip_en | input | 1 | Consume the current chip |
| code_index | input | 24 | Scrambling code index (r = 7:0, s = 15:8, t = 23:16) |
| chip_i | output | 2 | In-phase sign, 01 = +1, 11 = -1 |
| chip_q | output | 2 | Quadrature sign, 01 = +1, 11 = -1 |
| chip_valid | output | 1 | A chip is being presented |
| period_start | output | 1 | The presented chip is chip 0 |

## Verification
A restart and a chip advance can fall in the same cycle. The bench provokes this by raising `start` with a new index and `chip_en` together in the middle of a period. The scoreboard expects the old chip to be seen during that cycle, then chip 0 of the new index. No skipped or advanced chip is accepted. A period wrap, with chip 255 consumed while the index input is changing, is judged in the same way: the next expected chip is chip 0 of the latched index.

// File: rtl/ulsc_pkg.sv
package ulsc_pkg;

    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_BASE = 2'd1,
        SC_TAIL = 2'd2
    } sc_state_e;

    localparam logic [1:0] SGN_POS  = 2'b01;
    localparam logic [1:0] SGN_NEG  = 2'b11;
    localparam logic [1:0] SGN_NONE = 2'b00;

    // Returns {I, Q} signs for a quaternary symbol
    function automatic logic [3:0] map_symbol(input logic [1:0] z);
        logic [1:0] i_s;
        logic [1:0] q_s;
        i_s = (z == 2'd0 || z == 2'd3) ? SGN_POS : SGN_NEG;
        q_s = (z[1] == 1'b0) ? SGN_POS : SGN_NEG;
        return {i_s, q_s};
    endfunction

endpackage

// File: rtl/ulsc_quat_lfsr.sv
module ulsc_quat_lfsr #(
    parameter int unsigned           STAGES = 8,
    // coefficient for window position i sits at bits [2i+1:2i]
    parameter logic [2*STAGES-1:0]   COEF   = 16'h0C7B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [STAGES-1:0] seed,
    output logic [1:0]        sym
);

    logic [1:0] win_q [STAGES];
    logic [1:0] prod  [STAGES];
    logic [1:0] fb;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_prod
            assign prod[gi] = win_q[gi] * COEF[2*gi +: 2];
        end
    endgenerate

    always_comb begin
        fb = 2'd0;
        for (int k = 0; k < STAGES; k++) begin
            fb = fb + prod[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) win_q[k] <= 2'd0;
        end else if (load) begin
            win_q[0] <= {seed[0], 1'b1};
            for (int k = 1; k < STAGES; k++) win_q[k] <= {seed[k], 1'b0};
        end else if (step) begin
            for (int k = 0; k < STAGES - 1; k++) win_q[k] <= win_q[k+1];
            win_q[STAGES-1] <= fb;
        end
    end

    assign sym = win_q[0];

endmodule

// File: rtl/ulsc_bin_lfsr.sv
module ulsc_bin_lfsr #(
    parameter int unsigned         STAGES = 8,
    // bit i set: window position i feeds the new element
    parameter logic [STAGES-1:0]   TAPS   = 8'hA3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [STAGES-1:0] seed,
    output logic              bit_o
);

    logic [STAGES-1:0] win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (load) begin
            win_q <= seed;
        end else if (step) begin
            win_q <= {^(win_q & TAPS), win_q[STAGES-1:1]};
        end
    end

    assign bit_o = win_q[0];

endmodule

// File: rtl/ulsc_short_code_gen.sv
module ulsc_short_code_gen
    import ulsc_pkg::*;
#(
    parameter int unsigned            STAGES  = 8,
    parameter logic [2*STAGES-1:0]    A_COEF  = 16'h0C7B,
    parameter logic [STAGES-1:0]      B_TAPS  = 8'hA3,
    parameter logic [STAGES-1:0]      C_TAPS  = 8'h39,
    localparam int unsigned           IDX_W   = 3 * STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             chip_en,
    input  logic [IDX_W-1:0] code_index,
    output logic [1:0]       chip_i,
    output logic [1:0]       chip_q,
    output logic             chip_valid,
    output logic             period_start
);

    localparam int unsigned       CHIPS     = 1 << STAGES;
    localparam logic [STAGES-1:0] LAST_BASE = STAGES'(CHIPS - 2);

    sc_state_e         state_q, state_d;
    logic [STAGES-1:0] cnt_q, cnt_d;
    logic [IDX_W-1:0]  idx_q;
    logic [1:0]        first_q;
    logic              gen_load, gen_step, use_latched, cap_first;
    logic [IDX_W-1:0]  seed_word;
    logic [1:0]        a_sym;
    logic              b_bit, c_bit;
    logic [1:0]        z_gen, z_cur;
    logic [3:0]        signs;

    assign seed_word = use_latched ? idx_q : code_index;

    ulsc_quat_lfsr #(.STAGES(STAGES), .COEF(A_COEF)) u_gen_a (
        .clk(clk), .rst_n(rst_n), .load(gen_load), .step(gen_step),
        .seed(seed_word[0 +: STAGES]), .sym(a_sym)
    );

    ulsc_bin_lfsr #(.STAGES(STAGES), .TAPS(B_TAPS)) u_gen_b (
        .clk(clk), .rst_n(rst_n), .load(gen_load), .step(gen_step),
        .seed(seed_word[STAGES +: STAGES]), .bit_o(b_bit)
    );

    ulsc_bin_lfsr #(.STAGES(STAGES), .TAPS(C_TAPS)) u_gen_c (
        .clk(clk), .rst_n(rst_n), .load(gen_load), .step(gen_step),
        .seed(seed_word[2*STAGES +: STAGES]), .bit_o(c_bit)
    );

    // z = a + 2b + 2c mod 4: binary terms only touch the upper bit
    assign z_gen = {a_sym[1] ^ b_bit ^ c_bit, a_sym[0]};

    // next-state and control
    always_comb begin
        state_d     = state_q;
        cnt_d       = cnt_q;
        gen_load    = 1'b0;
        gen_step    = 1'b0;
        use_latched = 1'b0;
        cap_first   = 1'b0;
        if (start) begin
            state_d  = SC_BASE;
            cnt_d    = '0;
            gen_load = 1'b1;
        end else begin
            unique case (state_q)
                SC_IDLE: begin
                    state_d = SC_IDLE;
                end
                SC_BASE: begin
                    if (chip_en) begin
                        cap_first = (cnt_q == '0);
                        cnt_d     = cnt_q + 1'b1;
                        if (cnt_q == LAST_BASE) begin
                            state_d = SC_TAIL;
                        end else begin
                            gen_step = 1'b1;
                        end
                    end
                end
                SC_TAIL: begin
                    if (chip_en) begin
                        state_d     = SC_BASE;
                        cnt_d       = '0;
                        gen_load    = 1'b1;
                        use_latched = 1'b1;
                    end
                end
                default: begin
                    state_d = SC_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SC_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            first_q <= 2'd0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (start)     idx_q   <= code_index;
            if (cap_first) first_q <= z_gen;
        end
    end

    // outputs
    always_comb begin
        z_cur        = (state_q == SC_TAIL) ? first_q : z_gen;
        signs        = map_symbol(z_cur);
        chip_valid   = 1'b0;
        period_start = 1'b0;
        chip_i       = SGN_NONE;
        chip_q       = SGN_NONE;
        unique case (state_q)
            SC_IDLE: begin
                chip_valid = 1'b0;
            end
            SC_BASE, SC_TAIL: begin
                chip_valid   = 1'b1;
                period_start = (state_q == SC_BASE) && (cnt_q == '0);
                chip_i       = signs[3:2];
                chip_q       = signs[1:0];
            end
            default: begin
                chip_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ulsc_short_code_chk.sv
module ulsc_short_code_chk #(
    parameter int unsigned STAGES = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       chip_en,
    input logic [1:0] chip_i,
    input logic [1:0] chip_q,
    input logic       chip_valid,
    input logic       period_start
);

    logic [STAGES-1:0] pos_q;
    logic [3:0]        first_q;
    logic              seen_start_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q        <= '0;
            first_q      <= 4'd0;
            seen_start_q <= 1'b0;
        end else begin
            if (start) begin
                pos_q        <= '0;
                seen_start_q <= 1'b1;
            end else if (chip_valid && chip_en) begin
                pos_q <= pos_q + 1'b1;
                if (pos_q == '0) first_q <= {chip_i, chip_q};
            end
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_start_q |-> (!chip_valid && !period_start));

    a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (chip_valid && period_start));

    a_r5_legal_signs: assert property (@(posedge clk) disable iff (!rst_n)
        chip_valid |-> ((chip_i == 2'b01 || chip_i == 2'b11) &&
                        (chip_q == 2'b01 || chip_q == 2'b11)));

    a_r6_tail_repeats: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_valid && seen_start_q && pos_q == '1) |-> ({chip_i, chip_q} == first_q));

    a_r7_wrap_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_valid && chip_en && !start && pos_q == '1) |=> period_start);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_valid && !chip_en && !start) |=>
            ($stable(chip_i) && $stable(chip_q) && $stable(period_start) && chip_valid));

endmodule

bind ulsc_short_code_gen ulsc_short_code_chk #(.STAGES(STAGES)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .chip_en(chip_en),
    .chip_i(chip_i), .chip_q(chip_q), .chip_valid(chip_valid),
    .period_start(period_start)
);

// File: tb/ulsc_short_code_gen_tb_top.sv
module ulsc_short_code_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        chip_en = 1'b0;
    logic [23:0] code_index = '0;
    logic [1:0]  chip_i, chip_q;
    logic        chip_valid, period_start;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    ulsc_short_code_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .chip_en(chip_en),
        .code_index(code_index), .chip_i(chip_i), .chip_q(chip_q),
        .chip_valid(chip_valid), .period_start(period_start)
    );

    // reference sequence for the current index
    int zexp [256];
    int pos;

    logic [4:0] exp_q [$];
    string      tag_q [$];

    function automatic logic [4:0] expect_at(int p);
        logic [1:0] i_s, q_s;
        int z;
        z = zexp[p];
        i_s = (z == 0 || z == 3) ? 2'b01 : 2'b11;
        q_s = (z == 0 || z == 1) ? 2'b01 : 2'b11;
        return {i_s, q_s, (p == 0) ? 1'b1 : 1'b0};
    endfunction

    task automatic build(input logic [23:0] idx);
        int a [255];
        int b [255];
        int c [255];
        for (int i = 0; i < 8; i++) begin
            a[i] = (i == 0) ? (2 * idx[0] + 1) % 4 : (2 * idx[i]) % 4;
            b[i] = idx[8 + i];
            c[i] = idx[16 + i];
        end
        for (int n = 8; n < 255; n++) begin
            a[n] = (3*a[n-3] + a[n-5] + 3*a[n-6] + 2*a[n-7] + 3*a[n-8]) % 4;
            b[n] = (b[n-1] + b[n-3] + b[n-7] + b[n-8]) % 2;
            c[n] = (c[n-3] + c[n-4] + c[n-5] + c[n-8]) % 2;
        end
        for (int n = 0; n < 255; n++) zexp[n] = (a[n] + 2*b[n] + 2*c[n]) % 4;
        zexp[255] = zexp[0];
    endtask

    function automatic string tag_for(int p);
        if (p == 255) return "R6";
        if (p == 0)   return "R2/R7";
        if (p < 8)    return "R3/R4/R5";
        return "R5";
    endfunction

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got {i,q,ps}=%b expected %b", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per consumed chip
    always @(negedge clk) begin
        if (rst_n && chip_en && exp_q.size() > 0) begin
            logic [4:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {chip_i, chip_q, period_start}, e);
            n_checks++;
            if (chip_valid !== 1'b1) begin
                n_fails++;
                $display("FAIL %s: chip_valid=%b expected 1", t, chip_valid);
            end
        end
    end

    // driver tasks, entered at posedge + 1
    task automatic do_start(input logic [23:0] idx);
        code_index = idx;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        build(idx);
        pos = 0;
    endtask

    task automatic consume(input string tag);
        exp_q.push_back(expect_at(pos));
        tag_q.push_back(tag);
        chip_en = 1'b1;
        @(posedge clk); #1;
        chip_en = 1'b0;
        pos = (pos + 1) % 256;
    endtask

    task automatic hold_gap();
        chip_en = 1'b0;
        @(negedge clk);
        check("R8", {chip_i, chip_q, period_start}, expect_at(pos));
        @(posedge clk); #1;
    endtask

    task automatic run(input int n, input int gap_every);
        for (int k = 0; k < n; k++) begin
            consume(tag_for(pos));
            if (gap_every > 0 && (k % gap_every) == gap_every - 1) hold_gap();
        end
    endtask

    initial begin
        #(200000 * 10);
        n_fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1", {chip_i, chip_q, chip_valid}, 5'b0);
        check("R1", {4'b0, period_start}, 5'b0);
        // chip_en before any start has no effect
        chip_en = 1'b1;
        repeat (3) @(posedge clk);
        #1 chip_en = 1'b0;
        @(negedge clk);
        check("R1", {chip_i, chip_q, chip_valid}, 5'b0);
        @(posedge clk); #1;

        // index 0: full period plus wrap
        do_start(24'h000000);
        @(negedge clk);
        check("R2", {chip_i, chip_q, period_start}, expect_at(0));
        @(posedge clk); #1;
        run(256 + 6, 0);

        // mixed index with holds; index changes mid-period are ignored (R10)
        do_start(24'hC35A96);
        run(40, 5);
        code_index = 24'h0F0F0F;
        run(230, 7);
        code_index = 24'h777777;
        run(20, 0);

        // restart coinciding with chip_en (R9)
        code_index = 24'hFFFFFF;
        start = 1'b1;
        exp_q.push_back(expect_at(pos));
        tag_q.push_back("R9");
        chip_en = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        chip_en = 1'b0;
        build(24'hFFFFFF);
        pos = 0;
        @(negedge clk);
        check("R9", {chip_i, chip_q, period_start}, expect_at(0));
        @(posedge clk); #1;
        run(260, 0);

        // plain restart mid-period without chip_en
        run(50, 0);
        do_start(24'h123456);
        @(negedge clk);
        check("R2", {chip_i, chip_q, period_start}, expect_at(0));
        @(posedge clk); #1;
        run(258, 11);

        repeat (3) @(posedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule